// File: doc/BRIEF.md
# Regulator power-state sequencer

This block is the digital control state machine of a buck-boost switching regulator. It takes a master enable, a forced-bypass request, an undervoltage flag, a buck-to-boost crossover flag and a digitised die temperature. From these it decides whether the converter runs, whether the bypass path is closed, and whether the output soft-discharge resistor is switched in. It also produces the soft-start reference code that the analog reference follows. The comparators, switches and resistors are outside the block; only their digital controls are produced here.

After enable, the block waits a settle interval and then ramps the reference code up to its final value. The ramp slows for the rest of the ramp once a crossover into boost operation is flagged. Once the ramp is complete the block regulates. From regulation it can enter forced bypass. It holds bypass for a minimum dwell time, and after bypass it refuses re-entry until a lockout interval has passed. Undervoltage and over-temperature override everything except enable. The temperature trip has hysteresis. Recovery from any fault restarts the settle interval and a fresh ramp from zero.

All intervals are given in microseconds and converted to clock cycles with a cycles-per-microsecond parameter.

Top module: `regseq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, dis_en_o is 1 and conv_run_o, byp_sw_o and ref_code_o are all 0.
- R2: In the cycle after en_i is sampled low, dis_en_o is 1 and conv_run_o and byp_sw_o are 0. From the second such cycle on, ref_code_o is 0.
- R3: When en_i is first sampled high (with no fault), conv_run_o rises on the (SETTLE_CYC+1)-th rising edge counted from that edge. ref_code_o is 0 in that first soft-start cycle.
- R4: During soft-start without crossover, ref_code_o rises by exactly 1 every FAST_DIV cycles and stops at REF_FINAL. The block then regulates with conv_run_o still 1 and ref_code_o held at REF_FINAL. ref_code_o never decreases while conv_run_o stays 1 and never exceeds REF_FINAL.
- R5: If xover_i is 1 in any soft-start cycle, then from the next cycle until the ramp ends every step takes SLOW_DIV cycles, even if xover_i returns to 0.
- R6: In regulation with the lockout expired, a byp_req_i sampled high makes byp_sw_o 1 in the next cycle, with conv_run_o 0 during bypass. A bypass with no fault lasts max(h, BYP_MIN_CYC) cycles, where h is the first bypass cycle at whose end byp_req_i is sampled low.
- R7: After byp_sw_o falls, it stays 0 for at least BYP_LOCK_CYC cycles. A request that is asserted during the lockout and kept high is honoured, so that byp_sw_o rises after exactly BYP_LOCK_CYC low cycles.
- R8: temp_i is an unsigned code at 1 °C per LSB. A value of 150 or more makes conv_run_o and byp_sw_o 0 from the second cycle on. A value of 149 has no effect.
- R9: After a trip, the block stays off while temp_i is above 115. When temp_i is first sampled at 115 or less, conv_run_o rises on the (SETTLE_CYC+2)-th edge from that edge, with ref_code_o restarting from 0.
- R10: uv_i sampled high makes conv_run_o and byp_sw_o 0 in the next cycle, while dis_en_o stays 0. conv_run_o rises again on the SETTLE_CYC-th edge after uv_i is first sampled low.
- R11: A fault during bypass ends the bypass in the next cycle, whatever dwell time is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Master enable; low means power-down |
| byp_req_i | input | 1 | Forced-bypass request (level) |
| uv_i | input | 1 | Supply undervoltage flag, already synchronised |
| temp_i | input | TEMP_W | Die temperature code, 1 °C per LSB |
| xover_i | input | 1 | Buck-to-boost crossover flag during soft-start |
| conv_run_o | output | 1 | Converter switching allowed |
| byp_sw_o | output | 1 | Close the direct input-to-output bypass path |
| dis_en_o | output | 1 | Switch in the output soft-discharge resistor |
| ref_code_o | output | REF_W | Soft-start reference code |

## Verification
The bound assertions check, on every cycle, the responses that follow within one or two cycles: enable low, undervoltage, a temperature trip and holding off while the trip flag is set. They also check that the reference never falls or overshoots during conversion, and use their own counters to check the minimum bypass dwell and the minimum re-entry lockout. Only the bench scenarios show the exact settle delays after enable, undervoltage and thermal recovery, and the exact step intervals of the fast ramp and the slowed ramp. They also show that a latched crossover keeps the ramp slow after the flag drops, that a held request re-enters bypass exactly when the lockout ends, and that a fault cuts a bypass short.

// File: rtl/regseq_pkg.sv
// Shared types and helpers for the regulator power-state sequencer.
// Assumes all timing is expressed as whole microseconds and a clock whose
// rate is an integer number of cycles per microsecond.
package regseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SSTART = 3'd2,
        ST_REGUL  = 3'd3,
        ST_BYPASS = 3'd4,
        ST_TSHUT  = 3'd5
    } seq_state_e;

    // Convert a duration in microseconds to clock cycles.
    function automatic int unsigned us_to_cyc(input int unsigned us,
                                              input int unsigned per_us);
        return us * per_us;
    endfunction

endpackage

// File: rtl/regseq_thermal.sv
// Over-temperature flag with hysteresis.
// Sets when the temperature code reaches TRIP_C and clears only once it
// falls to CLEAR_C or below. Assumes CLEAR_C < TRIP_C and a code of 1 °C/LSB.
module regseq_thermal #(
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned TRIP_C  = 150,
    parameter int unsigned CLEAR_C = 115
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hot_o
);

    logic hot_q;

    // Hysteretic trip register: set at or above trip, clear at or below release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (temp_i >= TEMP_W'(TRIP_C)) begin
            hot_q <= 1'b1;
        end else if (temp_i <= TEMP_W'(CLEAR_C)) begin
            hot_q <= 1'b0;
        end
    end

    assign hot_o = hot_q;

endmodule

// File: rtl/regseq_ramp.sv
// Soft-start reference ramp generator.
// While run_i is high the code steps up by one every FAST_DIV cycles, or
// every SLOW_DIV cycles once a crossover has been seen in this ramp; the
// slow rate is latched until clr_i. The code saturates at REF_FINAL and holds
// whenever neither run_i nor clr_i is set. Assumes SLOW_DIV >= FAST_DIV >= 1.
module regseq_ramp #(
    parameter int unsigned REF_W     = 8,
    parameter int unsigned REF_FINAL = 200,
    parameter int unsigned FAST_DIV  = 2,
    parameter int unsigned SLOW_DIV  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             xover_i,
    output logic [REF_W-1:0] code_o,
    output logic             top_o
);

    localparam int unsigned DIV_W = $clog2(SLOW_DIV + 1);

    logic             slow_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [REF_W-1:0] code_q;
    logic             at_top;

    // Pick the step interval for the current ramp rate.
    always_comb begin
        div_lim = slow_q ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
        at_top  = (code_q == REF_W'(REF_FINAL));
    end

    // Ramp state: rate latch, step divider and reference code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= 1'b0;
            div_q  <= '0;
            code_q <= '0;
        end else if (clr_i) begin
            slow_q <= 1'b0;
            div_q  <= '0;
            code_q <= '0;
        end else if (run_i) begin
            if (xover_i) begin
                slow_q <= 1'b1;
            end
            if (!at_top) begin
                if (div_q >= div_lim) begin
                    div_q  <= '0;
                    code_q <= code_q + 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign code_o = code_q;
    assign top_o  = at_top;

endmodule

// File: rtl/regseq_byp_guard.sv
// Bypass dwell and re-entry lockout timers.
// dwell_done_o rises once the block has been in bypass for MIN_CYC cycles.
// reentry_ok_o is low for LOCK_CYC cycles after the last bypass cycle, so a
// request held through the lockout enters bypass after exactly LOCK_CYC idle
// cycles. Assumes MIN_CYC >= 1 and LOCK_CYC >= 1.
module regseq_byp_guard #(
    parameter int unsigned MIN_CYC  = 800,
    parameter int unsigned LOCK_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_byp_i,
    output logic dwell_done_o,
    output logic reentry_ok_o
);

    localparam int unsigned DW_W = $clog2(MIN_CYC + 1);
    localparam int unsigned LK_W = $clog2(LOCK_CYC + 1);

    logic [DW_W-1:0] dwell_q;
    logic [LK_W-1:0] lock_q;

    // Dwell counter: counts bypass cycles, saturating at MIN_CYC-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (!in_byp_i) begin
            dwell_q <= '0;
        end else if (dwell_q != DW_W'(MIN_CYC - 1)) begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    // Lockout counter: reloaded during bypass, counts down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (in_byp_i) begin
            lock_q <= LK_W'(LOCK_CYC - 1);
        end else if (lock_q != '0) begin
            lock_q <= lock_q - 1'b1;
        end
    end

    assign dwell_done_o = in_byp_i && (dwell_q == DW_W'(MIN_CYC - 1));
    assign reentry_ok_o = (lock_q == '0);

endmodule

// File: rtl/regseq_top.sv
// Regulator power-state sequencer, top level.
// A Moore state machine over off, settle, soft-start, regulate, forced bypass
// and thermal shutdown. Priority: enable low, then over-temperature, then
// undervoltage, then the normal sequence. Every fault recovery passes through
// settle. Assumes uv_i, en_i, byp_req_i and xover_i are synchronous to clk.
module regseq_top #(
    parameter int unsigned CLK_PER_US  = 1,
    parameter int unsigned SETTLE_US   = 1000,
    parameter int unsigned BYP_MIN_US  = 800,
    parameter int unsigned BYP_LOCK_US = 1000,
    parameter int unsigned TEMP_W      = 8,
    parameter int unsigned TRIP_C      = 150,
    parameter int unsigned CLEAR_C     = 115,
    parameter int unsigned REF_W       = 8,
    parameter int unsigned REF_FINAL   = 200,
    parameter int unsigned FAST_DIV    = 2,
    parameter int unsigned SLOW_DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              byp_req_i,
    input  logic              uv_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              xover_i,
    output logic              conv_run_o,
    output logic              byp_sw_o,
    output logic              dis_en_o,
    output logic [REF_W-1:0]  ref_code_o
);

    import regseq_pkg::*;

    localparam int unsigned SETTLE_CYC   = us_to_cyc(SETTLE_US, CLK_PER_US);
    localparam int unsigned BYP_MIN_CYC  = us_to_cyc(BYP_MIN_US, CLK_PER_US);
    localparam int unsigned BYP_LOCK_CYC = us_to_cyc(BYP_LOCK_US, CLK_PER_US);
    localparam int unsigned SET_W        = $clog2(SETTLE_CYC + 1);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [SET_W-1:0] settle_q;
    logic             hot_q;
    logic             ramp_top;
    logic             dwell_done;
    logic             reentry_ok;
    logic             in_byp;
    logic             ramp_run;
    logic             ramp_clr;

    regseq_thermal #(
        .TEMP_W (TEMP_W),
        .TRIP_C (TRIP_C),
        .CLEAR_C(CLEAR_C)
    ) u_thermal (
        .clk   (clk),
        .rst_n (rst_n),
        .temp_i(temp_i),
        .hot_o (hot_q)
    );

    regseq_ramp #(
        .REF_W    (REF_W),
        .REF_FINAL(REF_FINAL),
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ramp_run),
        .clr_i  (ramp_clr),
        .xover_i(xover_i),
        .code_o (ref_code_o),
        .top_o  (ramp_top)
    );

    regseq_byp_guard #(
        .MIN_CYC (BYP_MIN_CYC),
        .LOCK_CYC(BYP_LOCK_CYC)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_byp_i    (in_byp),
        .dwell_done_o(dwell_done),
        .reentry_ok_o(reentry_ok)
    );

    // Next-state logic with fault priority ahead of the normal sequence.
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else if (hot_q) begin
            state_d = ST_TSHUT;
        end else if (uv_i) begin
            state_d = ST_SETTLE;
        end else begin
            case (state_q)
                ST_OFF:    state_d = ST_SETTLE;
                ST_SETTLE: if (settle_q == SET_W'(SETTLE_CYC - 1)) state_d = ST_SSTART;
                ST_SSTART: if (ramp_top) state_d = ST_REGUL;
                ST_REGUL:  if (byp_req_i && reentry_ok) state_d = ST_BYPASS;
                ST_BYPASS: if (!byp_req_i && dwell_done) state_d = ST_REGUL;
                ST_TSHUT:  state_d = ST_SETTLE;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Settle timer: counts fault-free cycles spent in settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (state_q == ST_SETTLE && state_d == ST_SETTLE && !uv_i) begin
            settle_q <= settle_q + 1'b1;
        end else begin
            settle_q <= '0;
        end
    end

    // State decode for outputs and sub-block controls.
    always_comb begin
        in_byp     = (state_q == ST_BYPASS);
        ramp_run   = (state_q == ST_SSTART);
        ramp_clr   = (state_q == ST_OFF) || (state_q == ST_SETTLE) || (state_q == ST_TSHUT);
        conv_run_o = (state_q == ST_SSTART) || (state_q == ST_REGUL);
        byp_sw_o   = in_byp;
        dis_en_o   = (state_q == ST_OFF);
    end

endmodule

// File: rtl/regseq_chk.sv
// Assertion checker for regseq_top, attached with bind below.
// Observes ports and the thermal flag; keeps its own counters for the bypass
// dwell and re-entry lockout windows.
module regseq_chk #(
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned TRIP_C    = 150,
    parameter int unsigned REF_W     = 8,
    parameter int unsigned REF_FINAL = 200,
    parameter int unsigned MIN_CYC   = 800,
    parameter int unsigned LOCK_CYC  = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              uv_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic              conv_run_o,
    input logic              byp_sw_o,
    input logic              dis_en_o,
    input logic [REF_W-1:0]  ref_code_o,
    input logic              hot_q
);

    localparam int unsigned LW = $clog2(MIN_CYC + 2);
    localparam int unsigned GW = $clog2(LOCK_CYC + 2);

    logic [LW-1:0] byp_len;
    logic [GW-1:0] gap_len;
    logic          seen_byp;

    // Length of the current bypass, saturating at MIN_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_len <= '0;
        end else if (!byp_sw_o) begin
            byp_len <= '0;
        end else if (byp_len != LW'(MIN_CYC)) begin
            byp_len <= byp_len + 1'b1;
        end
    end

    // Idle cycles since the last bypass, saturating at LOCK_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_len  <= '0;
            seen_byp <= 1'b0;
        end else if (byp_sw_o) begin
            gap_len  <= '0;
            seen_byp <= 1'b1;
        end else if (gap_len != GW'(LOCK_CYC)) begin
            gap_len <= gap_len + 1'b1;
        end
    end

    // R2
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (dis_en_o && !conv_run_o && !byp_sw_o));

    // R10
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && uv_i) |=> (!conv_run_o && !byp_sw_o && !dis_en_o));

    // R8
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i >= TEMP_W'(TRIP_C)) |=> ##1 (!conv_run_o && !byp_sw_o));

    // R9
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_q |=> (!conv_run_o && !byp_sw_o));

    // R4
    ref_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_run_o && $past(conv_run_o)) |-> (ref_code_o >= $past(ref_code_o)));

    // R4
    ref_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code_o <= REF_W'(REF_FINAL));

    // R6
    byp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_sw_o |-> (!conv_run_o && !dis_en_o));

    // R6
    dwell_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(byp_sw_o) && $past(en_i && !uv_i && !hot_q)) |-> (byp_len >= LW'(MIN_CYC)));

    // R7
    lockout_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(byp_sw_o) && seen_byp) |-> (gap_len >= GW'(LOCK_CYC)));

endmodule

bind regseq_top regseq_chk #(
    .TEMP_W   (TEMP_W),
    .TRIP_C   (TRIP_C),
    .REF_W    (REF_W),
    .REF_FINAL(REF_FINAL),
    .MIN_CYC  (BYP_MIN_CYC),
    .LOCK_CYC (BYP_LOCK_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .uv_i      (uv_i),
    .temp_i    (temp_i),
    .conv_run_o(conv_run_o),
    .byp_sw_o  (byp_sw_o),
    .dis_en_o  (dis_en_o),
    .ref_code_o(ref_code_o),
    .hot_q     (hot_q)
);

// File: tb/regseq_top_bench.sv
// Self-checking bench for regseq_top: directed sequences plus random bypass
// hold times and random sub-trip temperatures from a fixed seed.
module regseq_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 1000;
    localparam int BMIN       = 800;
    localparam int BLOCK      = 1000;
    localparam int FINAL      = 200;
    localparam int FAST       = 2;
    localparam int SLOW       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       byp_req_i = 1'b0;
    logic       uv_i = 1'b0;
    logic [7:0] temp_i = 8'd25;
    logic       xover_i = 1'b0;
    logic       conv_run_o;
    logic       byp_sw_o;
    logic       dis_en_o;
    logic [7:0] ref_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    regseq_top #(
        .CLK_PER_US(1), .SETTLE_US(SETTLE), .BYP_MIN_US(BMIN), .BYP_LOCK_US(BLOCK),
        .TEMP_W(8), .TRIP_C(150), .CLEAR_C(115), .REF_W(8), .REF_FINAL(FINAL),
        .FAST_DIV(FAST), .SLOW_DIV(SLOW)
    ) u_regseq_top (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .byp_req_i(byp_req_i), .uv_i(uv_i),
        .temp_i(temp_i), .xover_i(xover_i), .conv_run_o(conv_run_o),
        .byp_sw_o(byp_sw_o), .dis_en_o(dis_en_o), .ref_code_o(ref_code_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected bypass length for a request dropped at bypass cycle h.
    function automatic int exp_byp_len(input int h);
        return (h > BMIN) ? h : BMIN;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges with conv_run_o low until it rises.
    task automatic count_to_run(output int zeros);
        zeros = 0;
        @(negedge clk);
        while (!conv_run_o && zeros < 20000) begin
            zeros++;
            @(negedge clk);
        end
    endtask

    // Follow a ramp from its first cycle; optionally raise xover for one cycle.
    task automatic watch_ramp(input int xo_step, output int n_bad, output int n_steps);
        int last_code;
        int last_t;
        int t;
        bit slow_now;
        last_code = int'(ref_code_o);
        last_t = 0; t = 0; n_bad = 0; n_steps = 0; slow_now = 1'b0;
        while (int'(ref_code_o) != FINAL && t < 10000) begin
            @(negedge clk);
            t++;
            xover_i = 1'b0;
            if (int'(ref_code_o) != last_code) begin
                n_steps++;
                if ((t - last_t) != (slow_now ? SLOW : FAST) || int'(ref_code_o) != last_code + 1)
                    n_bad++;
                last_code = int'(ref_code_o);
                last_t = t;
                if (n_steps == xo_step) begin
                    xover_i = 1'b1;
                    slow_now = 1'b1;
                end
            end
        end
    endtask

    task automatic wait_regul();
        int n = 0;
        while (!(conv_run_o && int'(ref_code_o) == FINAL) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int zeros;
        int bad;
        int steps;
        int len;
        int gap;
        int h;
        void'($urandom(32'd7301));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dis_en_o && !conv_run_o && !byp_sw_o && ref_code_o == 0, "R1 reset outputs",
            {dis_en_o, conv_run_o, byp_sw_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dis_en_o && !conv_run_o && ref_code_o == 0, "R1 after reset", dis_en_o, 1);

        // R3: settle delay after enable
        en_i = 1'b1;
        count_to_run(zeros);
        chk(zeros == SETTLE, "R3 settle cycles", zeros, SETTLE);
        chk(ref_code_o == 0, "R3 ramp starts at 0", ref_code_o, 0);

        // R4: fast ramp
        watch_ramp(-1, bad, steps);
        chk(bad == 0, "R4 fast step interval errors", bad, 0);
        chk(steps == FINAL, "R4 fast step count", steps, FINAL);
        repeat (10) @(negedge clk);
        chk(conv_run_o && ref_code_o == FINAL, "R4 regulating at final", ref_code_o, FINAL);

        // R6: bypass entry one cycle after request
        byp_req_i = 1'b1;
        @(negedge clk);
        chk(byp_sw_o && !conv_run_o, "R6 bypass entry", byp_sw_o, 1);

        // R6/R7: chained bypasses with directed and random hold times
        for (int it = 0; it < 6; it++) begin
            if (it == 0) h = 1;
            else if (it == 1) h = BMIN;
            else if (it == 2) h = BMIN + 1;
            else h = int'($urandom_range(1200, 1));
            len = 1;
            for (int i = 1; i < h; i++) begin
                @(negedge clk);
                if (byp_sw_o) len++;
            end
            byp_req_i = 1'b0;
            @(negedge clk);
            while (byp_sw_o && len < 5000) begin
                len++;
                @(negedge clk);
            end
            chk(len == exp_byp_len(h), "R6 bypass length", len, exp_byp_len(h));
            chk(conv_run_o, "R6 regulation after bypass", conv_run_o, 1);
            if (it < 5) begin
                // R7: request held during lockout is honoured exactly at its end
                byp_req_i = 1'b1;
                gap = 1;
                @(negedge clk);
                while (!byp_sw_o && gap < 5000) begin
                    gap++;
                    @(negedge clk);
                end
                chk(gap == BLOCK, "R7 lockout idle cycles", gap, BLOCK);
            end
        end

        // R11/R10: undervoltage cuts bypass short, then restarts
        repeat (BLOCK + 5) @(negedge clk);
        byp_req_i = 1'b1;
        @(negedge clk);
        chk(byp_sw_o, "R11 bypass re-entered", byp_sw_o, 1);
        repeat (4) @(negedge clk);
        uv_i = 1'b1;
        @(negedge clk);
        chk(!byp_sw_o && !conv_run_o, "R11 fault ends bypass", byp_sw_o, 0);
        byp_req_i = 1'b0;
        repeat (30) @(negedge clk);
        chk(!conv_run_o && !dis_en_o, "R10 off during undervoltage", conv_run_o, 0);
        uv_i = 1'b0;
        count_to_run(zeros);
        chk(zeros == SETTLE - 1, "R10 restart delay", zeros, SETTLE - 1);
        wait_regul();

        // R8: random sub-trip temperatures have no effect
        for (int k = 0; k < 20; k++) begin
            temp_i = 8'($urandom_range(149, 0));
            repeat (3) @(negedge clk);
            chk(conv_run_o, "R8 below trip keeps running", conv_run_o, 1);
        end
        temp_i = 8'd149;
        repeat (10) @(negedge clk);
        chk(conv_run_o, "R8 149 no trip", conv_run_o, 1);
        temp_i = 8'd150;
        @(negedge clk);
        @(negedge clk);
        chk(!conv_run_o && !byp_sw_o, "R8 trip at 150", conv_run_o, 0);

        // R9: hysteresis and restart
        temp_i = 8'd116;
        repeat (50) @(negedge clk);
        chk(!conv_run_o && !dis_en_o, "R9 held off at 116", conv_run_o, 0);
        temp_i = 8'd115;
        count_to_run(zeros);
        chk(zeros == SETTLE + 1, "R9 recovery delay", zeros, SETTLE + 1);
        chk(ref_code_o == 0, "R9 ramp restarts at 0", ref_code_o, 0);
        wait_regul();

        // R2: enable low
        en_i = 1'b0;
        @(negedge clk);
        chk(dis_en_o && !conv_run_o && !byp_sw_o, "R2 power-down", dis_en_o, 1);
        @(negedge clk);
        chk(ref_code_o == 0, "R2 reference cleared", ref_code_o, 0);

        // R5: crossover slows the rest of the ramp
        en_i = 1'b1;
        count_to_run(zeros);
        watch_ramp(50, bad, steps);
        chk(bad == 0, "R5 slowed step interval errors", bad, 0);
        chk(steps == FINAL, "R5 step count", steps, FINAL);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule